// File: doc/BRIEF.md
# Single-Bus Accumulator Processor Core

This block is a compact accumulator processor built around one shared 16-bit internal bus. It runs programs held in a 4096-word, 16-bit, word-addressed memory inside the module. Every instruction is one 16-bit word. The upper 4 bits hold the operation code and the lower 12 bits hold a word address.

A control sequencer steps through three fetch cycles, one decode cycle and one or two execute cycles. In each cycle it selects at most one bus source by a numeric device code: 0 none, 1 address register, 2 program counter, 3 buffer register, 4 accumulator, 5 input register, 6 output register, 7 instruction register, 8 memory read data. Two transfers bypass the bus on private wires: accumulator to buffer register, and accumulator plus buffer register into the adder/subtractor.

A surrounding system uses the core as follows. It places a program in memory and releases reset, and the core starts at address 0. The system offers bytes on an 8-bit input port with a strobe. It collects bytes from an 8-bit output port qualified by a one-cycle valid flag, and it watches a halted flag.

Top module: `acc_bus_cpu`

## Requirements
- R1: While reset is active, and in the first cycle after it, halted and out_valid are low and out_data is zero.
- R2: Execution starts at address 0 and proceeds in address order. A halt instruction placed at address 0 raises halted exactly 5 clock edges after reset is released (3 fetch cycles, 1 decode cycle, 1 execute cycle).
- R3: Opcode 1 copies the memory word at the 12-bit address into the accumulator. Opcode 2 writes the accumulator to that address, and the stored word reads back unchanged with all 16 bits intact.
- R4: Opcode 3 adds the memory word to the accumulator and opcode 4 subtracts it. Both use two's complement and wrap modulo 2^16 (0x7FFF+1 gives 0x8000, 0x0000-1 gives 0xFFFF).
- R5: The input register captures in_data only in a cycle where in_strobe is high. Opcode 5 loads that byte into bits 7:0 of the accumulator and clears bits 15:8.
- R6: Opcode 6 puts accumulator bits 7:0 on out_data and raises out_valid for exactly one cycle.
- R7: Opcode 7 raises halted. The core then stays halted, with no further out_valid pulses and a frozen program counter, until reset.
- R8: Opcode 8 skips the next instruction (program counter gets one extra increment) when a condition holds. The condition is chosen by instruction bits 11:10: 00 = accumulator negative, 01 = accumulator zero, 10 = accumulator positive (nonzero, sign clear), 11 = never.
- R9: Opcode 9 sets the program counter to the 12-bit address field.
- R10: Opcodes 0 and 10 to 15 change no architectural state, and execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Byte offered to the input register |
| in_strobe | input | 1 | Captures in_data into the input register |
| out_data | output | 8 | Contents of the output register |
| out_valid | output | 1 | One-cycle pulse when out_data is refreshed |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The built-in properties assume the program in memory was placed there while reset was held, so the memory never changes under a running sequencer except through a store. They also assume in_strobe is a plain synchronous level, and that reset is applied before the first run. The bench keeps to these assumptions: it fills memory only while rst_n is low, and it drives in_data and in_strobe on falling edges. Every program ends in a halt instruction, so each run stops with a known output history that the bench compares against values worked out by hand from the requirements.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd1;
   localparam logic [OPC_W-1:0] OPC_STORE = 4'd2;
   localparam logic [OPC_W-1:0] OPC_ADD   = 4'd3;
   localparam logic [OPC_W-1:0] OPC_SUB   = 4'd4;
   localparam logic [OPC_W-1:0] OPC_IN    = 4'd5;
   localparam logic [OPC_W-1:0] OPC_OUT   = 4'd6;
   localparam logic [OPC_W-1:0] OPC_HALT  = 4'd7;
   localparam logic [OPC_W-1:0] OPC_SKIP  = 4'd8;
   localparam logic [OPC_W-1:0] OPC_JUMP  = 4'd9;

   // bus source device codes
   typedef enum logic [3:0] {
      BS_NONE = 4'd0,
      BS_MAR  = 4'd1,
      BS_PC   = 4'd2,
      BS_MBR  = 4'd3,
      BS_AC   = 4'd4,
      BS_IN   = 4'd5,
      BS_OUT  = 4'd6,
      BS_IR   = 4'd7,
      BS_MEM  = 4'd8
   } bus_src_e;

   typedef enum logic [2:0] {
      ST_F1, ST_F2, ST_F3, ST_DEC, ST_EX1, ST_EX2, ST_HALT
   } seq_state_e;

   typedef enum logic [2:0] {
      AC_HOLD, AC_BUS, AC_INB, AC_ADD, AC_SUB
   } ac_op_e;

   typedef struct packed {
      bus_src_e bus_sel;
      logic     ld_mar;
      logic     ld_mbr_bus;
      logic     ld_mbr_ac;
      logic     ld_ir;
      logic     pc_inc;
      logic     ld_pc;
      ac_op_e   ac_op;
      logic     ld_out;
      logic     mem_we;
   } ctrl_t;

endpackage

// File: rtl/acc_word_mem.sv
module acc_word_mem #(
   parameter int AW = 12,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("acc_word_mem: AW out of supported range");
   end

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
   end

   assign rdata = cells[addr];
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
   parameter int DW            = 16,
   parameter bit SUB_VIA_ADDER = 1'b1
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          sub,
   output logic [DW-1:0] y
);
   if (DW < 2) begin : g_bad_dw
      $error("acc_alu: DW too small");
   end

   if (SUB_VIA_ADDER) begin : g_shared
      logic [DW-1:0] b_eff;
      always_comb begin
         b_eff = sub ? ~b : b;
         y     = a + b_eff + DW'(sub);
      end
   end else begin : g_split
      always_comb begin
         y = sub ? (a - b) : (a + b);
      end
   end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_cpu_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   input  logic [1:0]       skip_code,
   input  logic             ac_neg,
   input  logic             ac_zero,
   output ctrl_t            ctrl,
   output logic             halted
);
   seq_state_e st, st_nx;
   logic       skip_take;

   always_comb begin
      case (skip_code)
         2'b00:   skip_take = ac_neg;
         2'b01:   skip_take = ac_zero;
         2'b10:   skip_take = !ac_neg && !ac_zero;
         default: skip_take = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_F1;
      else        st <= st_nx;
   end

   always_comb begin
      ctrl         = '0;
      ctrl.bus_sel = BS_NONE;
      ctrl.ac_op   = AC_HOLD;
      st_nx        = st;
      case (st)
         ST_F1: begin
            ctrl.bus_sel = BS_PC;
            ctrl.ld_mar  = 1'b1;
            st_nx        = ST_F2;
         end
         ST_F2: begin
            ctrl.bus_sel    = BS_MEM;
            ctrl.ld_mbr_bus = 1'b1;
            st_nx           = ST_F3;
         end
         ST_F3: begin
            ctrl.bus_sel = BS_MBR;
            ctrl.ld_ir   = 1'b1;
            ctrl.pc_inc  = 1'b1;
            st_nx        = ST_DEC;
         end
         ST_DEC: begin
            ctrl.bus_sel = BS_IR;
            ctrl.ld_mar  = 1'b1;
            st_nx        = ST_EX1;
         end
         ST_EX1: begin
            st_nx = ST_F1;
            case (opcode)
               OPC_LOAD, OPC_ADD, OPC_SUB: begin
                  ctrl.bus_sel    = BS_MEM;
                  ctrl.ld_mbr_bus = 1'b1;
                  st_nx           = ST_EX2;
               end
               OPC_STORE: begin
                  ctrl.ld_mbr_ac = 1'b1;
                  st_nx          = ST_EX2;
               end
               OPC_IN: begin
                  ctrl.bus_sel = BS_IN;
                  ctrl.ac_op   = AC_INB;
               end
               OPC_OUT: begin
                  ctrl.bus_sel = BS_AC;
                  ctrl.ld_out  = 1'b1;
               end
               OPC_HALT: st_nx = ST_HALT;
               OPC_SKIP: ctrl.pc_inc = skip_take;
               OPC_JUMP: begin
                  ctrl.bus_sel = BS_IR;
                  ctrl.ld_pc   = 1'b1;
               end
               default: ;
            endcase
         end
         ST_EX2: begin
            st_nx = ST_F1;
            case (opcode)
               OPC_LOAD: begin
                  ctrl.bus_sel = BS_MBR;
                  ctrl.ac_op   = AC_BUS;
               end
               OPC_STORE: begin
                  ctrl.bus_sel = BS_MBR;
                  ctrl.mem_we  = 1'b1;
               end
               OPC_ADD: ctrl.ac_op = AC_ADD;
               OPC_SUB: ctrl.ac_op = AC_SUB;
               default: ;
            endcase
         end
         ST_HALT: st_nx = ST_HALT;
         default: st_nx = ST_F1;
      endcase
   end

   assign halted = (st == ST_HALT);

   AST_FETCH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_F1) |=> (st == ST_F2)); // R2

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R7
endmodule

// File: rtl/acc_bus_cpu.sv
module acc_bus_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int ADDR_W        = 12,
   parameter int OP_W          = 4,
   parameter int IO_W          = 8,
   parameter bit SUB_VIA_ADDER = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IO_W-1:0] in_data,
   input  logic            in_strobe,
   output logic [IO_W-1:0] out_data,
   output logic            out_valid,
   output logic            halted
);
   localparam int PAD_A  = DATA_W - ADDR_W;
   localparam int PAD_IO = DATA_W - IO_W;

   if (DATA_W != OP_W + ADDR_W) begin : g_bad_split
      $error("acc_bus_cpu: opcode plus address must fill a data word");
   end
   if (OP_W != OPC_W) begin : g_bad_op
      $error("acc_bus_cpu: opcode width must match the package");
   end
   if (IO_W >= DATA_W || ADDR_W >= DATA_W) begin : g_bad_io
      $error("acc_bus_cpu: port registers must be narrower than a word");
   end

   logic [DATA_W-1:0] ac, mbr, ir, bus, alu_y, mem_rd;
   logic [ADDR_W-1:0] mar, pc;
   logic [IO_W-1:0]   in_reg, out_reg;
   ctrl_t             ctrl;

   acc_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .opcode    (ir[DATA_W-1 -: OP_W]),
      .skip_code (ir[ADDR_W-1 -: 2]),
      .ac_neg    (ac[DATA_W-1]),
      .ac_zero   (ac == '0),
      .ctrl      (ctrl),
      .halted    (halted)
   );

   acc_word_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
      .clk   (clk),
      .we    (ctrl.mem_we),
      .addr  (mar),
      .wdata (bus),
      .rdata (mem_rd)
   );

   acc_alu #(.DW(DATA_W), .SUB_VIA_ADDER(SUB_VIA_ADDER)) u_alu (
      .a   (ac),
      .b   (mbr),
      .sub (ctrl.ac_op == AC_SUB),
      .y   (alu_y)
   );

   // shared bus: one source per cycle, picked by device code
   always_comb begin
      case (ctrl.bus_sel)
         BS_MAR:  bus = {{PAD_A{1'b0}}, mar};
         BS_PC:   bus = {{PAD_A{1'b0}}, pc};
         BS_MBR:  bus = mbr;
         BS_AC:   bus = ac;
         BS_IN:   bus = {{PAD_IO{1'b0}}, in_reg};
         BS_OUT:  bus = {{PAD_IO{1'b0}}, out_reg};
         BS_IR:   bus = ir;
         BS_MEM:  bus = mem_rd;
         default: bus = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac        <= '0;
         mbr       <= '0;
         ir        <= '0;
         mar       <= '0;
         pc        <= '0;
         in_reg    <= '0;
         out_reg   <= '0;
         out_valid <= 1'b0;
      end else begin
         if (ctrl.ld_mar)          mar <= bus[ADDR_W-1:0];
         if (ctrl.ld_mbr_bus)      mbr <= bus;
         else if (ctrl.ld_mbr_ac)  mbr <= ac;
         if (ctrl.ld_ir)           ir  <= bus;
         if (ctrl.ld_pc)           pc  <= bus[ADDR_W-1:0];
         else if (ctrl.pc_inc)     pc  <= pc + 1'b1;
         case (ctrl.ac_op)
            AC_BUS:          ac <= bus;
            AC_INB:          ac <= {{PAD_IO{1'b0}}, bus[IO_W-1:0]};
            AC_ADD, AC_SUB:  ac <= alu_y;
            default: ;
         endcase
         if (in_strobe)            in_reg  <= in_data;
         if (ctrl.ld_out)          out_reg <= bus[IO_W-1:0];
         out_valid <= ctrl.ld_out;
      end
   end

   assign out_data = out_reg;

   AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R6

   AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(pc)); // R7

   AST_IN_ZEROFILL: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.ac_op == AC_INB) |=> (ac[DATA_W-1:IO_W] == '0)); // R5

   AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.ld_pc |=> (pc == $past(ir[ADDR_W-1:0]))); // R9
endmodule

// File: tb/acc_bus_cpu_tb_top.sv
module acc_bus_cpu_tb_top;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_strobe = 1'b0;
   logic [7:0] out_data;
   logic       out_valid;
   logic       halted;

   int total = 0;
   int bad = 0;
   logic [7:0] out_log [16];
   int out_cnt = 0;
   int dbl_cnt = 0;
   logic prev_valid = 1'b0;

   acc_bus_cpu dut_i (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_strobe(in_strobe),
      .out_data(out_data), .out_valid(out_valid), .halted(halted)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (out_valid) begin
         if (out_cnt < 16) out_log[out_cnt] = out_data;
         out_cnt++;
         if (prev_valid) dbl_cnt++;
      end
      prev_valid = out_valid;
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ins(input int op, input int a);
      return {op[3:0], a[11:0]};
   endfunction

   task automatic put(input int a, input logic [15:0] w);
      dut_i.u_mem.cells[a] = w;
   endtask

   task automatic begin_prog();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 512; i++) put(i, 16'h7000);
      out_cnt = 0;
      dbl_cnt = 0;
   endtask

   task automatic run(output int cycles);
      @(negedge clk);
      rst_n = 1'b1;
      cycles = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         cycles++;
         if (halted) break;
      end
   endtask

   task automatic t_reset();
      int n;
      begin_prog();
      @(negedge clk);
      chk("R1", "halted in reset", halted, 0);
      chk("R1", "out_valid in reset", out_valid, 0);
      chk("R1", "out_data in reset", out_data, 0);
      put(0, ins(7, 0));
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "halted after release", halted, 0);
      chk("R1", "out_data after release", out_data, 0);
      rst_n = 1'b0;
      @(negedge clk);
      n = 0;
      run(n);
      chk("R2", "cycles to halt", n, 5);
   endtask

   task automatic t_load_add();
      int n;
      begin_prog();
      put(0, ins(1, 'h100)); put(1, ins(3, 'h101)); put(2, ins(6, 0)); put(3, ins(7, 0));
      put('h100, 16'h0012); put('h101, 16'h0034);
      run(n);
      chk("R4", "add result", out_log[0], 8'h46);
      chk("R6", "one output", out_cnt, 1);
      chk("R6", "pulse width", dbl_cnt, 0);
      chk("R7", "halted", halted, 1);
   endtask

   task automatic t_wrap();
      int n;
      begin_prog();
      put(0, ins(1, 'h100)); put(1, ins(3, 'h101)); put(2, 16'h8000); put(3, ins(7, 0));
      put(4, ins(6, 0)); put(5, ins(1, 'h102)); put(6, ins(4, 'h103)); put(7, ins(6, 0));
      put(8, 16'h8000); put(9, ins(7, 0)); put('hA, ins(6, 0)); put('hB, ins(7, 0));
      put('h100, 16'h7FFF); put('h101, 16'h0001); put('h102, 16'h0000); put('h103, 16'h0001);
      run(n);
      chk("R4", "wrap count", out_cnt, 3);
      chk("R4", "0x7FFF+1 low byte", out_log[0], 8'h00);
      chk("R4", "0-1 low byte", out_log[1], 8'hFF);
      chk("R8", "neg skip after sub", out_log[2], 8'hFF);
   endtask

   task automatic t_skip();
      int n;
      begin_prog();
      put(0, ins(1, 'h100)); put(1, 16'h8400); put(2, ins(6, 0)); put(3, 16'h8800);
      put(4, ins(6, 0)); put(5, 16'h8C00); put(6, ins(6, 0)); put(7, ins(1, 'h101));
      put(8, 16'h8400); put(9, ins(7, 0)); put('hA, ins(6, 0)); put('hB, 16'h8000);
      put('hC, ins(6, 0)); put('hD, ins(7, 0));
      put('h100, 16'h0005); put('h101, 16'h0000);
      run(n);
      chk("R8", "skip output count", out_cnt, 4);
      chk("R8", "zero not taken", out_log[0], 8'h05);
      chk("R8", "code 11 never", out_log[1], 8'h05);
      chk("R8", "zero taken", out_log[2], 8'h00);
      chk("R8", "neg not taken on zero", out_log[3], 8'h00);
   endtask

   task automatic t_store();
      int n;
      begin_prog();
      put(0, ins(1, 'h100)); put(1, ins(2, 'h120)); put(2, ins(1, 'h101)); put(3, ins(6, 0));
      put(4, ins(1, 'h120)); put(5, ins(6, 0)); put(6, 16'h8000); put(7, ins(7, 0));
      put(8, ins(6, 0)); put(9, ins(7, 0));
      put('h100, 16'hABCD); put('h101, 16'h0000); put('h120, 16'h0000);
      run(n);
      chk("R3", "store count", out_cnt, 3);
      chk("R3", "load zero", out_log[0], 8'h00);
      chk("R3", "stored low byte", out_log[1], 8'hCD);
      chk("R3", "stored sign bit", out_log[2], 8'hCD);
   endtask

   task automatic t_input();
      begin_prog();
      put(0, ins(5, 0)); put(1, 16'h8000); put(2, ins(6, 0)); put(3, ins(5, 0));
      put(4, ins(6, 0)); put(5, ins(7, 0));
      @(negedge clk);
      rst_n = 1'b1;
      in_data = 8'h9C;
      in_strobe = 1'b1;
      @(negedge clk);
      in_strobe = 1'b0;
      in_data = 8'h11;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (halted) break;
      end
      chk("R5", "input count", out_cnt, 2);
      chk("R5", "zero fill byte", out_log[0], 8'h9C);
      chk("R5", "no strobe ignored", out_log[1], 8'h9C);
   endtask

   task automatic t_jump_nop();
      int n;
      begin_prog();
      put(0, ins(9, 'h10)); put(1, ins(6, 0)); put(2, ins(7, 0));
      put('h10, 16'h0000); put('h11, 16'hF123); put('h12, 16'hA100);
      put('h13, ins(1, 'h100)); put('h14, ins(6, 0)); put('h15, ins(7, 0));
      put('h100, 16'h005A);
      run(n);
      chk("R9", "jump count", out_cnt, 1);
      chk("R10", "nops then load", out_log[0], 8'h5A);
   endtask

   task automatic t_halt();
      int n;
      begin_prog();
      put(0, ins(7, 0)); put(1, ins(6, 0)); put(2, ins(6, 0));
      run(n);
      repeat (60) @(negedge clk);
      chk("R7", "still halted", halted, 1);
      chk("R7", "no output after halt", out_cnt, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_load_add();
      t_wrap();
      t_skip();
      t_store();
      t_input();
      t_jump_nop();
      t_halt();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule